// File: doc/BRIEF.md
# Video Memory Write Drain with Byte-Lane Merge

This block sits behind the video write queue and retires its entries into two small on-chip word memories: a 64-word colour memory and a 40-word vertical-scroll memory. The queue presents its oldest entry together with the time at which that entry becomes due. The block compares that time with a free-running cycle count, pops the entry once it is due, and commits it in the same clock. No more than one entry is retired per clock.

Each entry carries an access code that selects the target memory. A full-word entry overwrites the indexed word. A byte entry is merged into the stored word by a single-cycle read-modify-write, and address bit 0 chooses which half of the word is replaced. Scroll-memory writes whose word index falls past the implemented words are discarded. Entries with any other access code are popped and write nothing. The pixel pipeline reads both memories through combinational read ports.

Top module: `cmem_drain`

## Requirements
- R1: While reset is held, and after its release until the first commit, every word of both memories reads 0 and `pop_o` is low.
- R2: `pop_o` is high in a cycle exactly when `head_valid_i` is high and the head is due. The head is due when bit 15 of (`now_i` − `head_due_i`) modulo 2^16 is 0, which makes the test safe across counter wrap.
- R3: Access code 4'h3 selects the colour memory and 4'h5 selects the scroll memory. A popped entry with any other code leaves both memories unchanged.
- R4: The colour memory word index is `head_addr_i[6:1]`, i.e. the address shifted right by one and kept modulo 64. All higher address bits are ignored.
- R5: The scroll memory word index is `head_addr_i[6:1]`. A scroll write whose index is 40 or more is dropped and changes no word.
- R6: A full-word entry (`head_partial_i` = 0) stores all 16 bits of `head_data_i` in the indexed word.
- R7: A byte entry at an odd address stores `head_data_i[7:0]` in bits 15:8 of the indexed word and keeps bits 7:0 of that word.
- R8: A byte entry at an even address stores `head_data_i[7:0]` in bits 7:0 of the indexed word and keeps bits 15:8 of that word.
- R9: A commit happens at the rising edge in which `pop_o` is high. The new word is visible on the combinational read port after that edge. A scroll read at index 40 or more returns 0.
- R10: While no entry is popped, no word in either memory changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| now_i | input | 16 | Free-running cycle count |
| head_valid_i | input | 1 | The queue head holds an entry |
| head_due_i | input | 16 | Cycle at which the head entry becomes due |
| head_addr_i | input | 16 | Byte address of the head entry |
| head_data_i | input | 16 | Data of the head entry; only bits 7:0 are used for byte entries |
| head_code_i | input | 4 | Access code selecting the target memory |
| head_partial_i | input | 1 | 1 = byte entry, 0 = full-word entry |
| pop_o | output | 1 | Head entry is retired at this clock edge |
| cram_raddr_i | input | 6 | Colour memory read index |
| cram_rdata_o | output | 16 | Colour memory read data |
| vsram_raddr_i | input | 6 | Scroll memory read index |
| vsram_rdata_o | output | 16 | Scroll memory read data, 0 at index 40 or more |

## Verification
Directed entries at even and odd addresses, in both word and byte form, separate the two byte lanes from a full overwrite. Each byte entry follows a word write to the same index, so a merge into the wrong lane, or one that does not keep the other lane, changes a known pattern. Scroll writes at indices 39, 40 and 63, colour writes with high address bits set, and an entry with an unmatched code separate the bound, the index masking and the target decode. Entries due in the future, due just before the counter wraps and due just after it test the due comparison. A long random stream with bunched due times is then followed by a sweep of both memories.

// File: rtl/cmem_drain_pkg.sv
package cmem_drain_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2
  } tgt_e;
endpackage

// File: rtl/drain_rst_sync.sv
module drain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/drain_due_gate.sv
module drain_due_gate #(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] due_i,
  input  logic              valid_i,
  output logic              pop_o
);
  logic [TIME_W-1:0] lag;

  // Wrap-safe: the head is due when now is at or past due in modular order.
  always_comb begin
    lag   = now_i - due_i;
    pop_o = valid_i && !lag[TIME_W-1];
  end
endmodule

// File: rtl/drain_lane_merge.sv
module drain_lane_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] new_i,
  input  logic         partial_i,
  input  logic         odd_i,
  output logic [W-1:0] word_o
);
  localparam int LANE_W = W / 2;

  always_comb begin
    if (!partial_i)  word_o = new_i;
    else if (odd_i)  word_o = {new_i[LANE_W-1:0], old_i[LANE_W-1:0]};
    else             word_o = {old_i[W-1:LANE_W], new_i[LANE_W-1:0]};
  end
endmodule

// File: rtl/drain_word_ram.sv
module drain_word_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [W-1:0]     rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [W-1:0]     rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic en;
    assign en = we_i && (waddr_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[g] <= '0;
      else if (en) mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = ({1'b0, raddr_a_i} < (IDX_W+1)'(DEPTH)) ? mem_q[raddr_a_i] : '0;
    rdata_b_o = ({1'b0, raddr_b_i} < (IDX_W+1)'(DEPTH)) ? mem_q[raddr_b_i] : '0;
  end

  // R9
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/cmem_drain.sv
module cmem_drain #(
  parameter int          TIME_W      = 16,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          CODE_W      = 4,
  parameter int          CRAM_DEPTH  = 64,
  parameter int          VSRAM_DEPTH = 40,
  parameter int          VSRAM_SPAN  = 64,
  parameter logic [3:0]  CODE_CRAM   = 4'h3,
  parameter logic [3:0]  CODE_VSRAM  = 4'h5,
  localparam int         CIDX_W      = $clog2(CRAM_DEPTH),
  localparam int         VIDX_W      = $clog2(VSRAM_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              head_valid_i,
  input  logic [TIME_W-1:0] head_due_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [CODE_W-1:0] head_code_i,
  input  logic              head_partial_i,
  output logic              pop_o,
  input  logic [CIDX_W-1:0] cram_raddr_i,
  output logic [DATA_W-1:0] cram_rdata_o,
  input  logic [VIDX_W-1:0] vsram_raddr_i,
  output logic [DATA_W-1:0] vsram_rdata_o
);
  import cmem_drain_pkg::*;

  logic              srst_n;
  tgt_e              tgt;
  logic [CIDX_W-1:0] c_idx;
  logic [VIDX_W-1:0] v_idx;
  logic              v_in_range;
  logic              c_we, v_we;
  logic [DATA_W-1:0] c_old, v_old, c_new, v_new;
  logic              unused_hi;

  drain_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  drain_due_gate #(.TIME_W(TIME_W)) u_due (
    .now_i(now_i), .due_i(head_due_i), .valid_i(head_valid_i), .pop_o(pop_o)
  );

  // Target decode and word indexing
  always_comb begin
    if (head_code_i == CODE_W'(CODE_CRAM))       tgt = TGT_CRAM;
    else if (head_code_i == CODE_W'(CODE_VSRAM)) tgt = TGT_VSRAM;
    else                                         tgt = TGT_NONE;
    c_idx      = head_addr_i[CIDX_W:1];
    v_idx      = head_addr_i[VIDX_W:1];
    v_in_range = ({1'b0, v_idx} < (VIDX_W+1)'(VSRAM_DEPTH));
    c_we       = pop_o && (tgt == TGT_CRAM);
    v_we       = pop_o && (tgt == TGT_VSRAM) && v_in_range;
  end

  assign unused_hi = ^{head_addr_i[ADDR_W-1:VIDX_W+1], head_addr_i[CIDX_W:1]};

  drain_lane_merge #(.W(DATA_W)) u_c_merge (
    .old_i(c_old), .new_i(head_data_i), .partial_i(head_partial_i),
    .odd_i(head_addr_i[0]), .word_o(c_new)
  );

  drain_lane_merge #(.W(DATA_W)) u_v_merge (
    .old_i(v_old), .new_i(head_data_i), .partial_i(head_partial_i),
    .odd_i(head_addr_i[0]), .word_o(v_new)
  );

  drain_word_ram #(.DEPTH(CRAM_DEPTH), .W(DATA_W), .IDX_W(CIDX_W)) u_cram (
    .clk(clk), .rst_n(srst_n), .we_i(c_we), .waddr_i(c_idx), .wdata_i(c_new),
    .raddr_a_i(c_idx), .rdata_a_o(c_old),
    .raddr_b_i(cram_raddr_i), .rdata_b_o(cram_rdata_o)
  );

  drain_word_ram #(.DEPTH(VSRAM_DEPTH), .W(DATA_W), .IDX_W(VIDX_W)) u_vsram (
    .clk(clk), .rst_n(srst_n), .we_i(v_we), .waddr_i(v_idx), .wdata_i(v_new),
    .raddr_a_i(v_idx), .rdata_a_o(v_old),
    .raddr_b_i(vsram_raddr_i), .rdata_b_o(vsram_rdata_o)
  );

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({c_we, v_we}));

  // R3
  no_code_match_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (pop_o && head_code_i != CODE_W'(CODE_CRAM) && head_code_i != CODE_W'(CODE_VSRAM))
      |-> !(c_we || v_we));

  // R5
  vsram_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    v_we |-> (int'(head_addr_i[VIDX_W:1]) < VSRAM_DEPTH));

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !pop_o |-> !(c_we || v_we));

  // R2
  pop_needs_head_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !head_valid_i |-> !pop_o);
endmodule

// File: tb/tb_cmem_drain.sv
module tb_cmem_drain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] now_i;
  logic        head_valid_i;
  logic [15:0] head_due_i, head_addr_i, head_data_i;
  logic [3:0]  head_code_i;
  logic        head_partial_i;
  logic        pop_o;
  logic [5:0]  cram_raddr_i, vsram_raddr_i;
  logic [15:0] cram_rdata_o, vsram_rdata_o;

  always #2 clk = ~clk;

  cmem_drain dut (.*);

  typedef struct {
    int    due;
    int    addr;
    int    data;
    int    code;
    bit    partial;
    string tag;
  } ent_t;

  ent_t  q[$];
  int    mc[64];
  int    mv[40];
  int    now, sweep, checks, errors;
  bit    done;
  bit    has_c, has_v;
  int    last_c, last_v;
  string tag_c, tag_v, idle_tag;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, now);
    end
  endtask

  task automatic push(int due, int addr, int data, int code, bit p, string tag);
    ent_t e;
    e.due = due; e.addr = addr; e.data = data; e.code = code; e.partial = p; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic int merge(int old, int d, bit p, int a);
    if (!p) return d & 'hFFFF;
    if (a & 1) return (old & 'hFF) | ((d & 'hFF) << 8);
    return (old & 'hFF00) | (d & 'hFF);
  endfunction

  function automatic void apply(ent_t e);
    int idx = (e.addr >> 1) & 63;
    if (e.code == 3) begin
      mc[idx] = merge(mc[idx], e.data, e.partial, e.addr);
      has_c = 1; last_c = idx; tag_c = e.tag;
    end else if (e.code == 5) begin
      if (idx < 40) begin
        mv[idx] = merge(mv[idx], e.data, e.partial, e.addr);
        has_v = 1; last_v = idx; tag_v = e.tag;
      end
    end else begin
      has_c = 1; last_c = idx; tag_c = e.tag;  // word must be unchanged
    end
  endfunction

  task automatic step();
    bit    exp_pop;
    int    ci, vi, ve;
    string ct, vt, pt;
    @(negedge clk);
    now_i = now[15:0];
    if (q.size() > 0) begin
      head_valid_i = 1'b1; head_due_i = q[0].due[15:0]; head_addr_i = q[0].addr[15:0];
      head_data_i = q[0].data[15:0]; head_code_i = q[0].code[3:0]; head_partial_i = q[0].partial;
    end else begin
      head_valid_i = 1'b0; head_due_i = '0; head_addr_i = '0;
      head_data_i = '0; head_code_i = '0; head_partial_i = 1'b0;
    end
    ci = has_c ? last_c : sweep % 64; ct = has_c ? tag_c : idle_tag;
    vi = has_v ? last_v : sweep % 64; vt = has_v ? tag_v : idle_tag;
    has_c = 0; has_v = 0;
    cram_raddr_i = ci[5:0]; vsram_raddr_i = vi[5:0];
    #1;
    exp_pop = (q.size() > 0) && ((((now - q[0].due) & 'hFFFF)) < 'h8000);
    pt = (q.size() > 0 && !exp_pop) ? "R10" : "R2";
    chk(pop_o == exp_pop, pt, pop_o, exp_pop);
    chk(cram_rdata_o == mc[ci][15:0], ct, cram_rdata_o, mc[ci]);
    ve = (vi < 40) ? mv[vi] : 0;  // R9 out-of-range read gives 0
    chk(vsram_rdata_o == ve[15:0], vt, vsram_rdata_o, ve);
    @(posedge clk);
    if (exp_pop) begin
      apply(q[0]);
      void'(q.pop_front());
    end
    now++; sweep++;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mc[i]) mc[i] = 0;
    foreach (mv[i]) mv[i] = 0;
    checks = 0; errors = 0; now = 100; sweep = 0; done = 0;
    has_c = 0; has_v = 0; last_c = 0; last_v = 0; idle_tag = "R1";
    rst_n = 1'b0; head_valid_i = 1'b0; now_i = '0; head_due_i = '0; head_addr_i = '0;
    head_data_i = '0; head_code_i = '0; head_partial_i = 1'b0;
    cram_raddr_i = '0; vsram_raddr_i = '0;
    repeat (4) @(posedge clk);
    #1;
    chk(pop_o == 1'b0, "R1", pop_o, 0);
    chk(cram_rdata_o == 16'h0, "R1", cram_rdata_o, 0);
    rst_n = 1'b1;
    // R1: sweep every word before any commit
    repeat (64) step();

    idle_tag = "R9";
    // R6 word writes, then R7/R8 byte lanes on top
    push(now, 'h0004, 'hA5C3, 3, 0, "R6");
    push(now, 'h0005, 'hFF12, 3, 1, "R7");   // idx2 -> 12C3
    push(now, 'h0004, 'hEE77, 3, 1, "R8");   // idx2 -> 1277
    push(now, 'h0010, 'h3C5A, 5, 0, "R6");
    push(now, 'h0011, 'h0099, 5, 1, "R7");   // vs idx8 -> 995A
    push(now, 'h0010, 'h0042, 5, 1, "R8");   // vs idx8 -> 9942
    push(now, 'h0022, 'hBEEF, 3, 1, "R8");   // idx17 from 0 -> 00EF
    push(now, 'h0023, 'h0001, 3, 1, "R7");   // idx17 -> 01EF
    // R4 high address bits ignored
    push(now, 'h107E, 'h1357, 3, 0, "R4");   // idx63
    push(now, 'hF803, 'h2468, 3, 0, "R4");   // idx1
    // R5 scroll bound
    push(now, 'h004E, 'h7777, 5, 0, "R5");   // idx39 kept
    push(now, 'h0050, 'h8888, 5, 0, "R5");   // idx40 dropped
    push(now, 'h007E, 'h9999, 5, 0, "R5");   // idx63 dropped
    push(now, 'h004F, 'h0011, 5, 1, "R5");   // idx39 -> 1177
    // R3 unmatched code leaves colour word idx2
    push(now, 'h0004, 'hDEAD, 7, 0, "R3");
    push(now, 'h0004, 'hDEAD, 0, 1, "R3");
    drain();

    // R10 entry due later must wait
    push(now + 6, 'h0030, 'h4321, 3, 0, "R10");
    push(now + 6, 'h0031, 'h00AB, 5, 1, "R10");
    drain();

    // R2 wrap of the cycle count
    now = 'hFFF8;
    push('hFFFE, 'h0040, 'h5555, 3, 0, "R2");
    push('h0003, 'h0041, 'h00CC, 3, 1, "R2");
    push('h0003, 'h0014, 'h6666, 5, 0, "R2");
    drain();

    // R9 random stream with bunched due times
    begin
      int d;
      int codes[5] = '{3, 5, 3, 5, 0};
      d = now + 3;
      for (int i = 0; i < 400; i++) begin
        int c;
        d = d + $urandom_range(0, 2);
        c = codes[$urandom_range(0, 4)];
        if (c == 0) c = $urandom_range(0, 15);
        push(d, $urandom_range(0, 255), $urandom_range(0, 65535), c,
             1'($urandom_range(0, 1)), "R9");
      end
    end
    drain();
    repeat (64) step();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule